// File: doc/BRIEF.md
# SDRAM Power-Up Command Sequencer

This block brings an SDRAM device out of power-up. After reset it waits a fixed number of clock cycles, then issues a fixed series of commands through a valid/acknowledge handshake with the SDRAM interface. The series is one precharge of all banks, eight auto-refresh commands, one mode register write and a final command that enters normal operation. Between two commands the block leaves a programmable number of idle cycles.

Once normal operation is entered, the block raises `ready` and keeps it high until the next reset. At the same moment it starts a two-stage refresh generator: a prescaler feeds a refresh timer, and each expiry of the timer raises a refresh request that stays pending until it is acknowledged. No refresh request can appear before `ready`.

The control is one state machine with four states:
- `ST_PWRUP` counts the power-up delay and then moves to `ST_ISSUE`.
- `ST_ISSUE` presents the current command. On an acknowledge it moves to `ST_GAP`. After the final command it moves to `ST_RUN` instead.
- `ST_GAP` counts the idle cycles between commands and then returns to `ST_ISSUE`.
- `ST_RUN` is terminal until reset.

A separate step tracker walks through the phases `PH_PREA`, `PH_AREF` (repeated eight times), `PH_MRS` and `PH_NORM`.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is held and right after it, `cmd_vld`=0, `cmd`=0 (NOP), `ready`=0 and `ref_req`=0.
- R2: `cmd_vld` first goes high on the PWRUP_CYC-th rising clock edge after reset is released. `cmd_ack` has no effect before that edge.
- R3: The commands are issued in this order with these codes: precharge-all = 1, then eight auto-refresh = 2, then mode register write = 3, then normal operation = 4.
- R4: While `cmd_vld` is high and `cmd_ack` is not sampled high on an edge, `cmd_vld` stays high and `cmd` stays unchanged.
- R5: After each acknowledged command other than the last, `cmd_vld` is low for exactly GAP_CYC cycles. `cmd_ack` has no effect during those cycles.
- R6: `ready` rises on the edge that accepts the normal-operation command and stays high until reset. From then on `cmd_vld` stays low.
- R7: `ref_req` is never high while `ready` is low.
- R8: With prescale value S and period value T, the refresh timer expires every (S+1)*(T+1) cycles. The first expiry falls on the (S+1)*(T+1)-th edge after the edge that raised `ready`, and every expiry sets `ref_req`.
- R9: `ref_req` stays high until `ref_ack` is sampled high on an edge that is not an expiry edge. A further expiry while a request is pending leaves a single request, which one acknowledge clears.
- R10: `cmd` is 0 (NOP) whenever `cmd_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_prescale | input | PS_W | Prescaler terminal value S (divides by S+1) |
| cfg_period | input | RT_W | Refresh timer terminal value T (counts T+1 prescaler wraps) |
| cmd_ack | input | 1 | Acknowledge of the presented command |
| ref_ack | input | 1 | Acknowledge of the pending refresh request |
| cmd | output | 3 | Command code: 0 NOP, 1 precharge-all, 2 auto-refresh, 3 mode write, 4 normal |
| cmd_vld | output | 1 | Command valid |
| ready | output | 1 | Normal operation entered |
| ref_req | output | 1 | Pending periodic refresh request |

## Verification
All timing is counted in rising edges:
- The first command is due on edge PWRUP_CYC after reset release.
- The next command is due GAP_CYC edges after the edge that acknowledges the previous one.
- `ready` is due on the very edge that accepts the normal-operation command.
- Refresh requests fall on multiples of (S+1)*(T+1) edges after `ready`.

The bench advances one edge at a time and samples 2 ns after each edge, counting edges to each expected event. It drives the handshake inputs before the edge on which they must count.

Its sweep covers four configurations. Each one uses a different pattern of acknowledge delays and a different pair of prescaler and timer values. Two of the runs hold `cmd_ack` high in stretches where it must be ignored. For the refresh requests, the bench keeps an arithmetic model of the pending bit and checks it on every cycle.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

    localparam int CMD_W = 3;

    // Command codes seen at the cmd port
    typedef enum logic [CMD_W-1:0] {
        CMD_NOP  = 3'd0,
        CMD_PREA = 3'd1,
        CMD_AREF = 3'd2,
        CMD_MRS  = 3'd3,
        CMD_NORM = 3'd4
    } sd_cmd_e;

    // Handshake state machine
    typedef enum logic [1:0] {
        ST_PWRUP,
        ST_ISSUE,
        ST_GAP,
        ST_RUN
    } seq_state_e;

    // Position in the command series
    typedef enum logic [1:0] {
        PH_PREA,
        PH_AREF,
        PH_MRS,
        PH_NORM
    } seq_phase_e;

endpackage

// File: rtl/sdram_seq_wait.sv
// Down counter shared by the power-up delay and the inter-command gap.
module sdram_seq_wait #(
    parameter int W       = 8,
    parameter int RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= W'(RST_VAL);
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sdram_seq_step.sv
// Tracks which command of the power-up series is current.
module sdram_seq_step
    import sdram_seq_pkg::*;
#(
    parameter int REF_COUNT = 8
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    adv,
    output sd_cmd_e cur_cmd,
    output logic    at_last
);

    localparam int REF_W = (REF_COUNT > 1) ? $clog2(REF_COUNT) : 1;
    localparam logic [REF_W-1:0] REF_LAST = REF_W'(REF_COUNT - 1);

    seq_phase_e       phase_q;
    logic [REF_W-1:0] rcnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_PREA;
            rcnt_q  <= '0;
        end else if (adv) begin
            unique case (phase_q)
                PH_PREA: begin
                    phase_q <= PH_AREF;
                    rcnt_q  <= '0;
                end
                PH_AREF: begin
                    if (rcnt_q == REF_LAST) begin
                        phase_q <= PH_MRS;
                    end else begin
                        rcnt_q <= rcnt_q + 1'b1;
                    end
                end
                PH_MRS:  phase_q <= PH_NORM;
                PH_NORM: phase_q <= PH_NORM;
            endcase
        end
    end

    always_comb begin
        unique case (phase_q)
            PH_PREA: cur_cmd = CMD_PREA;
            PH_AREF: cur_cmd = CMD_AREF;
            PH_MRS:  cur_cmd = CMD_MRS;
            PH_NORM: cur_cmd = CMD_NORM;
        endcase
    end

    assign at_last = (phase_q == PH_NORM);

endmodule

// File: rtl/sdram_seq_fsm.sv
// Handshake state machine: power-up wait, issue, gap, run.
module sdram_seq_fsm
    import sdram_seq_pkg::*;
#(
    parameter int W       = 8,
    parameter int GAP_CYC = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cmd_ack,
    input  logic         wait_done,
    input  sd_cmd_e      step_cmd,
    input  logic         step_last,
    output sd_cmd_e      cmd,
    output logic         cmd_vld,
    output logic         ready,
    output logic         step_adv,
    output logic         wait_load,
    output logic [W-1:0] wait_val
);

    localparam bit           HAS_GAP  = (GAP_CYC > 0);
    localparam logic [W-1:0] GAP_LOAD = HAS_GAP ? W'(GAP_CYC - 1) : '0;

    seq_state_e state_q, state_d;
    logic       accept;

    assign accept = (state_q == ST_ISSUE) && cmd_ack;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PWRUP;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PWRUP: if (wait_done) state_d = ST_ISSUE;
            ST_ISSUE: begin
                if (cmd_ack) begin
                    if (step_last)    state_d = ST_RUN;
                    else if (HAS_GAP) state_d = ST_GAP;
                    else              state_d = ST_ISSUE;
                end
            end
            ST_GAP:   if (wait_done) state_d = ST_ISSUE;
            ST_RUN:   state_d = ST_RUN;
        endcase
    end

    // Outputs
    always_comb begin
        cmd_vld   = (state_q == ST_ISSUE);
        cmd       = cmd_vld ? step_cmd : CMD_NOP;
        ready     = (state_q == ST_RUN);
        step_adv  = accept;
        wait_load = accept && !step_last && HAS_GAP;
        wait_val  = GAP_LOAD;
    end

endmodule

// File: rtl/sdram_refresh_gen.sv
// Two-stage periodic refresh request generator with a pending flag.
module sdram_refresh_gen #(
    parameter int PS_W = 8,
    parameter int RT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic [PS_W-1:0] cfg_prescale,
    input  logic [RT_W-1:0] cfg_period,
    input  logic            ref_ack,
    output logic            ref_req
);

    logic [PS_W-1:0] ps_q;
    logic [RT_W-1:0] rt_q;
    logic            ps_wrap;
    logic            expire;

    // >= keeps the stages bounded if the configuration shrinks mid-count
    assign ps_wrap = (ps_q >= cfg_prescale);
    assign expire  = enable && ps_wrap && (rt_q >= cfg_period);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ps_q    <= '0;
            rt_q    <= '0;
            ref_req <= 1'b0;
        end else if (!enable) begin
            ps_q    <= '0;
            rt_q    <= '0;
            ref_req <= 1'b0;
        end else begin
            if (ps_wrap) begin
                ps_q <= '0;
                if (rt_q >= cfg_period) rt_q <= '0;
                else                    rt_q <= rt_q + 1'b1;
            end else begin
                ps_q <= ps_q + 1'b1;
            end
            if (expire)       ref_req <= 1'b1;
            else if (ref_ack) ref_req <= 1'b0;
        end
    end

endmodule

// File: rtl/sdram_init_seq.sv
// SDRAM power-up command sequencer: top level.
module sdram_init_seq
    import sdram_seq_pkg::*;
#(
    parameter int PWRUP_CYC = 200,
    parameter int GAP_CYC   = 2,
    parameter int REF_COUNT = 8,
    parameter int PS_W      = 8,
    parameter int RT_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PS_W-1:0]  cfg_prescale,
    input  logic [RT_W-1:0]  cfg_period,
    input  logic             cmd_ack,
    input  logic             ref_ack,
    output logic [CMD_W-1:0] cmd,
    output logic             cmd_vld,
    output logic             ready,
    output logic             ref_req
);

    localparam int WAIT_MAX = (PWRUP_CYC > GAP_CYC) ? PWRUP_CYC : GAP_CYC;
    localparam int WAIT_W   = $clog2(WAIT_MAX + 1);
    localparam int PW_INIT  = (PWRUP_CYC > 0) ? PWRUP_CYC - 1 : 0;

    sd_cmd_e           step_cmd;
    sd_cmd_e           fsm_cmd;
    logic              step_last;
    logic              step_adv;
    logic              wait_load;
    logic              wait_done;
    logic [WAIT_W-1:0] wait_val;

    sdram_seq_wait #(
        .W       (WAIT_W),
        .RST_VAL (PW_INIT)
    ) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wait_load),
        .load_val (wait_val),
        .expired  (wait_done)
    );

    sdram_seq_step #(
        .REF_COUNT (REF_COUNT)
    ) u_step (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (step_adv),
        .cur_cmd (step_cmd),
        .at_last (step_last)
    );

    sdram_seq_fsm #(
        .W       (WAIT_W),
        .GAP_CYC (GAP_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_ack   (cmd_ack),
        .wait_done (wait_done),
        .step_cmd  (step_cmd),
        .step_last (step_last),
        .cmd       (fsm_cmd),
        .cmd_vld   (cmd_vld),
        .ready     (ready),
        .step_adv  (step_adv),
        .wait_load (wait_load),
        .wait_val  (wait_val)
    );

    sdram_refresh_gen #(
        .PS_W (PS_W),
        .RT_W (RT_W)
    ) u_refresh (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (ready),
        .cfg_prescale (cfg_prescale),
        .cfg_period   (cfg_period),
        .ref_ack      (ref_ack),
        .ref_req      (ref_req)
    );

    assign cmd = fsm_cmd;

endmodule

// File: rtl/sdram_seq_checker.sv
module sdram_seq_checker
    import sdram_seq_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [CMD_W-1:0] cmd,
    input logic             cmd_vld,
    input logic             cmd_ack,
    input logic             ready,
    input logic             ref_req,
    input logic             ref_ack
);

    p_hold_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_vld && !cmd_ack |=> cmd_vld && $stable(cmd));

    p_ready_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    p_quiet_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> !cmd_vld);

    p_no_early_ref_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !ref_req);

    p_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req && !ref_ack |=> ref_req);

    p_idle_nop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_vld |-> cmd == CMD_NOP);

endmodule

bind sdram_init_seq sdram_seq_checker u_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd     (cmd),
    .cmd_vld (cmd_vld),
    .cmd_ack (cmd_ack),
    .ready   (ready),
    .ref_req (ref_req),
    .ref_ack (ref_ack)
);

// File: tb/tb_sdram_init_seq.sv
module tb_sdram_init_seq;

    localparam int PW   = 10;
    localparam int GP   = 3;
    localparam int NREF = 8;
    localparam int NCMD = NREF + 3;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] cfg_prescale;
    logic [3:0] cfg_period;
    logic       cmd_ack;
    logic       ref_ack;
    logic [2:0] cmd;
    logic       cmd_vld;
    logic       ready;
    logic       ref_req;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    sdram_init_seq #(
        .PWRUP_CYC (PW),
        .GAP_CYC   (GP),
        .REF_COUNT (NREF),
        .PS_W      (4),
        .RT_W      (4)
    ) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_prescale (cfg_prescale),
        .cfg_period   (cfg_period),
        .cmd_ack      (cmd_ack),
        .ref_ack      (ref_ack),
        .cmd          (cmd),
        .cmd_vld      (cmd_vld),
        .ready        (ready),
        .ref_req      (ref_req)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    function automatic int exp_cmd(input int k);
        if (k == 0)         return 1;
        else if (k <= NREF) return 2;
        else if (k == NREF + 1) return 3;
        else                return 4;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        cmd_ack = 1'b0;
        ref_ack = 1'b0;
        cfg_prescale = 4'd0;
        cfg_period = 4'd0;
        for (int run = 0; run < 4; run++) begin
            int ps_v;
            int rt_v;
            int per;
            int n;
            bit expq;
            case (run)
                0: begin ps_v = 1; rt_v = 2; end
                1: begin ps_v = 0; rt_v = 3; end
                2: begin ps_v = 2; rt_v = 1; end
                default: begin ps_v = 3; rt_v = 0; end
            endcase
            per = (ps_v + 1) * (rt_v + 1);
            rst_n = 1'b0;
            cmd_ack = 1'b0;
            ref_ack = 1'b0;
            cfg_prescale = 4'(ps_v);
            cfg_period = 4'(rt_v);
            repeat (3) tick();
            // R1 reset state
            chk(cmd_vld == 1'b0, "R1 cmd_vld", int'(cmd_vld), 0);
            chk(cmd == 3'd0, "R1 cmd", int'(cmd), 0);
            chk(ready == 1'b0, "R1 ready", int'(ready), 0);
            chk(ref_req == 1'b0, "R1 ref_req", int'(ref_req), 0);
            rst_n = 1'b1;

            // R2 power-up delay, ack ignored on odd runs
            n = 0;
            while (!cmd_vld && n < 200) begin
                if (run % 2 == 1) cmd_ack = 1'b1;
                tick();
                n++;
            end
            cmd_ack = 1'b0;
            chk(n == PW, "R2 powerup edges", n, PW);

            for (int k = 0; k < NCMD; k++) begin
                int d;
                int g;
                // R3 command order
                chk(cmd == 3'(exp_cmd(k)), "R3 command", int'(cmd), exp_cmd(k));
                d = (k + run) % 4;
                for (int j = 0; j < d; j++) begin
                    tick();
                    chk(cmd_vld && cmd == 3'(exp_cmd(k)), "R4 hold", int'(cmd), exp_cmd(k));
                end
                cmd_ack = 1'b1;
                tick();
                cmd_ack = 1'b0;
                if (k < NCMD - 1) begin
                    g = 0;
                    while (!cmd_vld && g < 50) begin
                        chk(cmd == 3'd0, "R10 idle nop", int'(cmd), 0);
                        chk(!ready && !ref_req, "R7 early refresh", int'(ref_req), 0);
                        if (run % 2 == 1) cmd_ack = 1'b1;
                        tick();
                        g++;
                    end
                    cmd_ack = 1'b0;
                    chk(g == GP, "R5 gap", g, GP);
                end else begin
                    chk(ready == 1'b1, "R6 ready on accept", int'(ready), 1);
                    chk(cmd_vld == 1'b0 && cmd == 3'd0, "R6 quiet", int'(cmd_vld), 0);
                    chk(ref_req == 1'b0, "R7 no request yet", int'(ref_req), 0);
                end
            end

            // R8/R9 refresh requests against an arithmetic pending model
            expq = 1'b0;
            for (int t = 1; t <= 4 * per; t++) begin
                bit ackit;
                ackit = (t == per + 1) || (t == 3 * per + 1);
                ref_ack = ackit;
                tick();
                ref_ack = 1'b0;
                if (t % per == 0) expq = 1'b1;
                else if (ackit)   expq = 1'b0;
                chk(ref_req == expq, (t <= per) ? "R8 refresh period" : "R9 pending request",
                    int'(ref_req), int'(expq));
                chk(ready && !cmd_vld, "R6 sticky ready", int'(ready), 1);
            end
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule